// File: doc/BRIEF.md
# Serial Register Port for a Panel Controller

This block is the register side of a small panel controller, reached over a four-wire serial bus. The host opens a frame by pulling chip select low. The first byte of every frame is a start byte. It holds a fixed tag, a device-select bit and two bits that choose what the frame does:

- load the 16-bit index pointer;
- write the word the pointer selects;
- read the word the pointer selects;
- read a status word.

Bus pins are brought into the system clock domain by synchronisers, and every edge of the serial clock is detected there.

Behind the port sits a bank of 16-bit configuration words at indices 0x00 to 0x65.

- Index 0x00 reads back a fixed device code.
- Index 0x22 is not storage. It is the data port of the pixel memory: each word written there leaves the block as a one-cycle strobe with its data.
- A side port gives combinational read access to the stored words, for the display logic that uses them.

Top module: `panel_reg_spi`

## Requirements
- R1: After reset all stored words are 0x0000, the index pointer is 0x0000, `miso_o` is low and `px_we_o` is low.
- R2: Bus timing is SPI mode 0, MSB first: `mosi_i` is sampled on rising `sclk_i` and `miso_o` changes after falling `sclk_i`. The start byte layout is: bits 7..3 = 01110, bit 2 = device select (must equal `DEV_ID`, default 1), bit 1 = target (0 pointer/status, 1 register), bit 0 = direction (0 write, 1 read). With the default ID, the start bytes are 0x74 pointer write, 0x75 status read, 0x76 register write and 0x77 register read. A start byte with a wrong tag or a wrong device bit makes the rest of the frame inert: no state changes and `miso_o` stays low.
- R3: A pointer write frame (0x74, b1, b2) sets the index pointer to {b1,b2}.
- R4: A register write frame (0x76, hi, lo) stores {hi,lo} at an implemented index other than 0x22. The stored word is visible on `side_data_o` when `side_idx_i` selects it. Bytes after the third are ignored.
- R5: A register read frame (0x77, x, x) returns the selected word on `miso_o`: high byte in byte slot 1, low byte in slot 2.
- R6: A status read frame (0x75, x, x, x) returns 0x00 in slot 1 as a dummy byte. The index pointer follows, high byte in slot 2 and low byte in slot 3.
- R7: A read at index 0x0000 returns {0x922, `VARIANT`} (default 0x9221), whatever was written there. The side port shows the stored word.
- R8: Indices 0x0066 and above read as 0x0000 and discard writes, with no effect on any implemented word, including words whose low address bits match. The side port returns 0x0000 for such indices.
- R9: With the pointer at 0x0022, each complete (hi, lo) pair in a register write frame pulses `px_we_o` for one clock with `px_data_o` = {hi,lo}. Pixel writes change no configuration word. A read of index 0x22 returns 0x0000.
- R10: Raising `cs_ni` ends the frame. A partial byte or an unpaired data byte is discarded, and the first byte after chip select falls again is decoded as a start byte.
- R11: `miso_o` is low while `cs_ni` is high and throughout any frame that is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; it must run at least 6 times faster than `sclk_i` |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, idle low |
| cs_ni | input | 1 | Chip select, active low, frames each transaction |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| side_idx_i | input | 16 | Index for the side read port |
| side_data_o | output | 16 | Stored word at `side_idx_i`, zero if not stored |
| px_we_o | output | 1 | One-cycle pixel data write strobe |
| px_data_o | output | 16 | Pixel word that goes with `px_we_o` |

## Verification
The bench drives whole frames bit by bit and models the pointer, the word bank and the expected pixel stream. Every read is predicted from that model.

**Device code and status timing.** A read of index 0 that returned stored data instead of the device code would be caught. So would a status read that dropped the dummy slot, which would shift the pointer word one byte early.

**Out-of-range and aliased indices.** Pointers above 0x65 are written, including one whose low seven bits alias a live word. An implementation that truncated the index would corrupt that word, and a full sweep of the side port would show the damage.

**Rejected start bytes.** Start bytes with the wrong device bit or the wrong tag are sent. A decoder that ignored either field would write data or drive read data.

**Aborted frames and pixel bursts.** Frames are cut off mid-byte and mid-pair, and pixel bursts end with an unpaired byte. A design that kept partial state across chip select, or strobed on a half pair, would emit extra pixels or store stale words.

// File: rtl/panel_reg_pkg.sv
package panel_reg_pkg;

  localparam int WORD_W    = 16;
  localparam int IDX_W     = 16;
  localparam int PIXEL_IDX = 'h22;
  localparam logic [4:0] START_TAG = 5'b01110;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_IDX_WR,
    FR_STAT_RD,
    FR_REG_WR,
    FR_REG_RD,
    FR_DROP
  } frame_e;

  typedef struct packed {
    logic [4:0] tag;
    logic       dev;
    logic       tgt;
    logic       dir;
  } start_t;

  function automatic frame_e decode_start(logic [7:0] b, logic dev_id);
    start_t sb;
    sb = start_t'(b);
    if (sb.tag != START_TAG || sb.dev != dev_id) return FR_DROP;
    case ({sb.tgt, sb.dir})
      2'b00:   return FR_IDX_WR;
      2'b01:   return FR_STAT_RD;
      2'b10:   return FR_REG_WR;
      default: return FR_REG_RD;
    endcase
  endfunction

endpackage

// File: rtl/panel_sync.sv
module panel_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/panel_spi_shift.sv
module panel_spi_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_act_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic [2:0] slot_o,
  output logic [7:0] rx_byte_o,
  output logic [2:0] rx_slot_o,
  output logic       rx_valid_o,
  output logic       miso_o
);

  logic [2:0] bit_q;
  logic [2:0] slot_q;
  logic [6:0] sh_q;
  logic [7:0] tx_q;
  logic [7:0] rx_q;
  logic [2:0] rx_slot_q;
  logic       rx_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q      <= '0;
      slot_q     <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      rx_slot_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      if (!cs_act_i) begin
        bit_q  <= '0;
        slot_q <= '0;
        tx_q   <= '0;
      end else begin
        if (rise_i) begin
          sh_q  <= {sh_q[5:0], mosi_i};
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            rx_q       <= {sh_q, mosi_i};
            rx_slot_q  <= slot_q;
            rx_valid_q <= 1'b1;
            if (slot_q != 3'd7) slot_q <= slot_q + 3'd1;
          end
        end
        // byte boundary: present next byte's MSB; otherwise shift
        if (fall_i) tx_q <= (bit_q == 3'd0) ? tx_byte_i : {tx_q[6:0], 1'b0};
      end
    end
  end

  assign slot_o     = slot_q;
  assign rx_byte_o  = rx_q;
  assign rx_slot_o  = rx_slot_q;
  assign rx_valid_o = rx_valid_q;
  assign miso_o     = tx_q[7];

endmodule

// File: rtl/panel_reg_bank.sv
module panel_reg_bank #(
  parameter int NUM_REGS = 102,
  parameter int DW       = 16,
  parameter int AW       = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);

  logic [DW-1:0] mem_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[r] <= '0;
      else if (we_i && waddr_i == AW'(r))        mem_q[r] <= wdata_i;
    end
  end

  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (raddr_a_i == AW'(i)) rdata_a_o = mem_q[i];
      if (raddr_b_i == AW'(i)) rdata_b_o = mem_q[i];
    end
  end

endmodule

// File: rtl/panel_reg_spi.sv
module panel_reg_spi
  import panel_reg_pkg::*;
#(
  parameter logic        DEV_ID      = 1'b1,
  parameter logic [11:0] CODE_HI     = 12'h922,
  parameter logic [3:0]  VARIANT     = 4'h1,
  parameter int          NUM_REGS    = 102,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [IDX_W-1:0]  side_idx_i,
  output logic [WORD_W-1:0] side_data_o,
  output logic              px_we_o,
  output logic [WORD_W-1:0] px_data_o
);

  localparam int               AW     = $clog2(NUM_REGS);
  localparam logic [IDX_W-1:0] NREG_W = IDX_W'(NUM_REGS);
  localparam logic [IDX_W-1:0] PX_W   = IDX_W'(PIXEL_IDX);

  logic [2:0] sync_q;
  logic       sclk_s, cs_n_s, mosi_s, sclk_d_q;
  logic       rise, fall;

  panel_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i}),
    .q_o   (sync_q)
  );

  assign sclk_s = sync_q[2];
  assign cs_n_s = sync_q[1];
  assign mosi_s = sync_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_d_q;
  assign fall = ~sclk_s & sclk_d_q;

  logic [2:0]  tx_slot;
  logic [7:0]  rx_byte;
  logic [2:0]  rx_slot;
  logic        rx_valid;
  logic [7:0]  tx_byte;

  panel_spi_shift u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_act_i  (~cs_n_s),
    .rise_i    (rise),
    .fall_i    (fall),
    .mosi_i    (mosi_s),
    .tx_byte_i (tx_byte),
    .slot_o    (tx_slot),
    .rx_byte_o (rx_byte),
    .rx_slot_o (rx_slot),
    .rx_valid_o(rx_valid),
    .miso_o    (miso_o)
  );

  frame_e            frame_q;
  logic [7:0]        hold_q;
  logic              phase_q;
  logic [IDX_W-1:0]  index_q;
  logic              px_we_q;
  logic [WORD_W-1:0] px_data_q;

  logic idx_impl, idx_px;
  assign idx_impl = index_q < NREG_W;
  assign idx_px   = index_q == PX_W;

  logic              rf_we;
  logic [AW-1:0]     rf_waddr;
  logic [WORD_W-1:0] rf_rdata, side_raw, rd_word;

  assign rf_we    = rx_valid && !cs_n_s && frame_q == FR_REG_WR && rx_slot == 3'd2
                    && idx_impl && !idx_px;
  assign rf_waddr = index_q[AW-1:0];

  panel_reg_bank #(.NUM_REGS(NUM_REGS), .DW(WORD_W), .AW(AW)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rf_we),
    .waddr_i  (rf_waddr),
    .wdata_i  ({hold_q, rx_byte}),
    .raddr_a_i(index_q[AW-1:0]),
    .rdata_a_o(rf_rdata),
    .raddr_b_i(side_idx_i[AW-1:0]),
    .rdata_b_o(side_raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q   <= FR_IDLE;
      hold_q    <= '0;
      phase_q   <= 1'b0;
      index_q   <= '0;
      px_we_q   <= 1'b0;
      px_data_q <= '0;
    end else begin
      px_we_q <= 1'b0;
      if (cs_n_s) begin
        frame_q <= FR_IDLE;
        phase_q <= 1'b0;
      end else if (rx_valid) begin
        if (rx_slot == 3'd0) begin
          frame_q <= decode_start(rx_byte, DEV_ID);
        end else begin
          phase_q <= ~phase_q;
          if (!phase_q) hold_q <= rx_byte;
          if (frame_q == FR_IDX_WR && rx_slot == 3'd2) index_q <= {hold_q, rx_byte};
          if (frame_q == FR_REG_WR && phase_q && idx_px) begin
            px_we_q   <= 1'b1;
            px_data_q <= {hold_q, rx_byte};
          end
        end
      end
    end
  end

  always_comb begin
    if (index_q == '0)           rd_word = {CODE_HI, VARIANT};
    else if (idx_impl && !idx_px) rd_word = rf_rdata;
    else                          rd_word = '0;
  end

  always_comb begin
    tx_byte = 8'h00;
    case (frame_q)
      FR_REG_RD: begin
        if (tx_slot == 3'd1) tx_byte = rd_word[15:8];
        if (tx_slot == 3'd2) tx_byte = rd_word[7:0];
      end
      FR_STAT_RD: begin
        // slot 1 is the dummy byte
        if (tx_slot == 3'd2) tx_byte = index_q[15:8];
        if (tx_slot == 3'd3) tx_byte = index_q[7:0];
      end
      default: tx_byte = 8'h00;
    endcase
  end

  assign side_data_o = (side_idx_i < NREG_W && side_idx_i != PX_W) ? side_raw : '0;
  assign px_we_o     = px_we_q;
  assign px_data_o   = px_data_q;

endmodule

// File: rtl/panel_reg_spi_chk.sv
module panel_reg_spi_chk
  import panel_reg_pkg::*;
#(
  parameter int NUM_REGS = 102,
  parameter int AW       = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          miso_o,
  input logic          px_we_o,
  input frame_e        frame_q,
  input logic          rf_we,
  input logic [AW-1:0] rf_waddr
);

  a_r11_miso_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) |-> !miso_o);

  a_r11_miso_low_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_q == FR_IDX_WR || frame_q == FR_REG_WR || frame_q == FR_DROP) |-> !miso_o);

  a_r2_drop_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q == FR_DROP |-> !rf_we && !px_we_o);

  a_r9_px_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_we_o |=> !px_we_o);

  a_r9_px_not_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_we_o |-> !rf_we);

  a_r8_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we |-> rf_waddr < AW'(NUM_REGS) && rf_waddr != AW'(PIXEL_IDX));

endmodule

bind panel_reg_spi panel_reg_spi_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .miso_o  (miso_o),
  .px_we_o (px_we_o),
  .frame_q (frame_q),
  .rf_we   (rf_we),
  .rf_waddr(rf_waddr)
);

// File: tb/panel_reg_spi_tb_top.sv
module panel_reg_spi_tb_top;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        sclk, cs_n, mosi, miso_o;
  logic [15:0] side_idx_i, side_data_o, px_data_o;
  logic        px_we_o;

  always #10 clk = ~clk;

  panel_reg_spi dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk),
    .cs_ni      (cs_n),
    .mosi_i     (mosi),
    .miso_o     (miso_o),
    .side_idx_i (side_idx_i),
    .side_data_o(side_data_o),
    .px_we_o    (px_we_o),
    .px_data_o  (px_data_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0]  tx_buf [8];
  logic [7:0]  rx_buf [8];
  logic [15:0] m_reg  [128];
  logic [15:0] m_idx;
  logic [15:0] px_exp [$];
  logic [15:0] px_got [$];
  int cs_hi_cnt = 0, idle_bad = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-clock monitors
  always @(negedge clk) begin
    if (rst_ni && px_we_o) px_got.push_back(px_data_o);
    if (cs_n) cs_hi_cnt++; else cs_hi_cnt = 0;
    if (rst_ni && cs_hi_cnt > 4 && miso_o) idle_bad++;
  end

  function automatic logic [15:0] m_read(logic [15:0] idx);
    if (idx == 16'h0) return 16'h9221;
    if (idx < 16'h66 && idx != 16'h22) return m_reg[idx[6:0]];
    return 16'h0;
  endfunction

  function automatic logic [15:0] m_side(logic [15:0] idx);
    if (idx < 16'h66 && idx != 16'h22) return m_reg[idx[6:0]];
    return 16'h0;
  endfunction

  task automatic run_frame(int nbytes, int extra);
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbytes + 1; i++) begin
      for (int b = 7; b >= 0; b--) begin
        if (i == nbytes && (7 - b) >= extra) break;
        mosi = (i < nbytes) ? tx_buf[i][b] : 1'b1;
        repeat (HALF) @(negedge clk);
        if (i < nbytes) rx_buf[i][b] = miso_o;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
      end
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic t_idx(logic [15:0] v);
    tx_buf[0] = 8'h74; tx_buf[1] = v[15:8]; tx_buf[2] = v[7:0];
    run_frame(3, 0);
    m_idx = v;
  endtask

  task automatic t_wr(logic [15:0] v);
    tx_buf[0] = 8'h76; tx_buf[1] = v[15:8]; tx_buf[2] = v[7:0];
    run_frame(3, 0);
    chk("R11", "miso during write", {rx_buf[1], rx_buf[2]}, 32'h0);
    if (m_idx == 16'h22) px_exp.push_back(v);
    else if (m_idx < 16'h66) m_reg[m_idx[6:0]] = v;
  endtask

  task automatic t_rd(string req);
    tx_buf[0] = 8'h77; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
    run_frame(3, 0);
    chk(req, "register read", {rx_buf[1], rx_buf[2]}, {16'h0, m_read(m_idx)});
  endtask

  task automatic t_st(string req);
    tx_buf[0] = 8'h75; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
    run_frame(4, 0);
    chk(req, "status dummy", {24'h0, rx_buf[1]}, 32'h0);
    chk(req, "status word", {rx_buf[2], rx_buf[3]}, {16'h0, m_idx});
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 128; i++) begin
      side_idx_i = 16'(i);
      #1;
      chk(req, "side port", {16'h0, side_data_o}, {16'h0, m_side(16'(i))});
    end
    side_idx_i = 16'hFFFF;
    #1;
    chk(req, "side port high index", {16'h0, side_data_o}, 32'h0);
  endtask

  task automatic px_check(string req);
    chk(req, "pixel count", px_got.size(), px_exp.size());
    for (int i = 0; i < px_exp.size() && i < px_got.size(); i++)
      chk(req, "pixel data", {16'h0, px_got[i]}, {16'h0, px_exp[i]});
  endtask

  initial begin
    for (int i = 0; i < 128; i++) m_reg[i] = 16'h0;
    m_idx = 16'h0;
    rst_ni = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; side_idx_i = 16'h0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1", "miso after reset", {31'h0, miso_o}, 32'h0);
    chk("R1", "px_we after reset", {31'h0, px_we_o}, 32'h0);
    sweep("R1");
    t_st("R1");

    // R7 device code
    t_rd("R7");

    // R3 pointer write, R6 status
    t_idx(16'h0003);
    t_st("R3");
    t_idx(16'hA5C3);
    t_st("R6");

    // R4/R5 write and read back
    t_idx(16'h0003); t_wr(16'h1030); t_rd("R5");
    t_idx(16'h0065); t_wr(16'hBEEF); t_rd("R5");
    t_idx(16'h0010); t_wr(16'h4240); t_rd("R4");
    // extra bytes after slot 2 ignored
    tx_buf[0] = 8'h76; tx_buf[1] = 8'h13; tx_buf[2] = 8'h19; tx_buf[3] = 8'hEE; tx_buf[4] = 8'hFF;
    run_frame(5, 0);
    m_reg[16] = 16'h1319;
    t_rd("R4");
    sweep("R4");

    // R7 write at index 0 leaves the code
    t_idx(16'h0000); t_wr(16'h0001); t_rd("R7");
    side_idx_i = 16'h0; #1;
    chk("R7", "side port index 0", {16'h0, side_data_o}, 32'h0001);

    // R8 unimplemented indices
    t_idx(16'h0066); t_wr(16'h1234); t_rd("R8");
    t_idx(16'h00A5); t_wr(16'h5555); t_rd("R8");
    t_idx(16'h8003); t_wr(16'hAAAA); t_rd("R8");
    sweep("R8");

    // R2 rejected start bytes
    t_idx(16'h0003);
    tx_buf[0] = 8'h72; tx_buf[1] = 8'hAB; tx_buf[2] = 8'hCD; run_frame(3, 0);
    tx_buf[0] = 8'h36; tx_buf[1] = 8'hAB; tx_buf[2] = 8'hCD; run_frame(3, 0);
    tx_buf[0] = 8'h70; tx_buf[1] = 8'h00; tx_buf[2] = 8'h44; run_frame(3, 0);
    t_rd("R2");
    t_st("R2");
    tx_buf[0] = 8'h73; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; run_frame(3, 0);
    chk("R2", "wrong-ID read drives miso", {rx_buf[1], rx_buf[2]}, 32'h0);
    sweep("R2");

    // R9 pixel port
    t_idx(16'h0022); t_wr(16'hF800);
    tx_buf[0] = 8'h76; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22;
    tx_buf[3] = 8'h33; tx_buf[4] = 8'h44; tx_buf[5] = 8'h55;
    run_frame(6, 0);
    px_exp.push_back(16'h1122); px_exp.push_back(16'h3344);
    t_rd("R9");
    px_check("R9");
    sweep("R9");

    // R10 aborted frames
    t_idx(16'h0005);
    tx_buf[0] = 8'h76; tx_buf[1] = 8'h12; run_frame(2, 4);
    tx_buf[0] = 8'h76; tx_buf[1] = 8'h12; tx_buf[2] = 8'h34; run_frame(2, 7);
    t_rd("R10");
    tx_buf[0] = 8'h77; run_frame(0, 4);
    t_wr(16'h7E57); t_rd("R10");
    t_idx(16'h0022);
    tx_buf[0] = 8'h76; tx_buf[1] = 8'hAA; tx_buf[2] = 8'hBB; tx_buf[3] = 8'hCC;
    run_frame(4, 3);
    px_exp.push_back(16'hAABB);
    px_check("R10");
    sweep("R10");

    // R11 idle miso monitor
    chk("R11", "miso high while idle", idle_bad, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule